// File: doc/BRIEF.md
# Hidden Timing Register Window on Drive Task-File Ports

This block sits between a host and the task-file ports of one drive channel. It holds the channel's timing configuration registers, but gives them no address of their own. Instead, it watches the stream of host accesses to the eight port offsets. A fixed ordered sequence of accesses opens a configuration window. While the window is open, host accesses reach the configuration registers and are kept from the drive. A closing write returns the ports to plain pass-through.

The register file holds two timing sets, A and B. Each set has a read-cycle timing byte and a write-cycle timing byte. It also holds a control byte and a miscellaneous byte. Bit 0 of the miscellaneous byte chooses which set the two timing offsets address. Set B can only be reached once bit 6 of the control byte is set. All register values drive the channel's timing generator directly.

Host accesses last one clock cycle each. They are marked by a read or write strobe, a word/byte flag and a 3-bit offset. Accesses that the block does not take are forwarded to the drive as strobes in the same cycle.

Top module: `portcfg_window`

## Requirements
- R1: After reset the window is closed. Every timing byte of both sets reads 0xFF, the slowest setting. The miscellaneous byte is 0x30 (address setup field at maximum) and the control byte is 0x00.
- R2: The window opens only after this sequence: a word read at offset 1, then another word read at offset 1, then a byte write of 0x03 at offset 2, with nothing in between. Both reads are forwarded to the drive. The opening write is not forwarded.
- R3: Any access that breaks this order returns the detector to its locked start. Examples are another offset, a byte read at offset 1, a word write, or a write of any value other than 0x03. The breaking access is forwarded to the drive as a normal access.
- R4: While the window is open, a byte write of 0x83 at offset 2 closes it. That write is not forwarded to the drive.
- R5: While the window is open, no access reaches the drive. A read sets cfg_rvalid and returns the register value on rdata[7:0], with rdata[15:8] at zero. Reads of offsets 2, 4 and 7 return zero. Writes to offsets 2 (other than 0x83), 4, 5 and 7 change nothing. rdata is zero whenever cfg_rvalid is low.
- R6: While the window is open, offset 0 reaches the read-cycle timing byte and offset 1 reaches the write-cycle timing byte. When bit 0 of the miscellaneous byte is 0, these bytes belong to set A.
- R7: When bit 0 of the miscellaneous byte is 1, offsets 0 and 1 address set B, but only while bit 6 of the control byte is 1 (a write of 0xC0 sets it). When bit 6 is 0, writes to offsets 0 and 1 are dropped and reads of them return zero.
- R8: Offset 5 reads back the version value 0, and writes to it are ignored.
- R9: While the window is closed, every access is forwarded to the drive unchanged, except the opening write of R2. No configuration register changes.
- R10: While the window is open, offset 3 (control) and offset 6 (miscellaneous) are full-byte read/write registers. Their values appear on ctrl_q and misc_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_addr | input | 3 | Port offset of the host access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| host_wdata | input | 16 | Host write data; configuration writes use bits 7:0 |
| drv_rd | output | 1 | Read strobe forwarded to the drive |
| drv_wr | output | 1 | Write strobe forwarded to the drive |
| cfg_rvalid | output | 1 | The current read is served from the configuration registers |
| cfg_rdata | output | 16 | Configuration read data, zero when cfg_rvalid is low |
| win_open | output | 1 | Configuration window is open |
| tim_a_rd | output | 8 | Set A read-cycle timing |
| tim_a_wr | output | 8 | Set A write-cycle timing |
| tim_b_rd | output | 8 | Set B read-cycle timing |
| tim_b_wr | output | 8 | Set B write-cycle timing |
| misc_q | output | 8 | Miscellaneous byte (bit 0 selects the timing set) |
| ctrl_q | output | 8 | Control byte (bit 6 enables set B) |

## Verification
Two things can land on the same host access: the sequence detector deciding that its order is broken, and the pass-through deciding whether that access goes to the drive. An offset-2 write that carries the wrong value after two unlock reads, or a byte read at offset 1 between the two word reads, must both reset the detector and be forwarded. Random accesses are mixed with complete unlock sequences, and their data is biased toward 0x03, 0x83, 0xC0, 0x00 and 0x01, so these collisions occur often. Each access is judged in its own cycle on the drive strobes and read data. The register outputs and the window flag are judged after the next edge, and both are compared with a sequence-and-register model kept in the bench.

// File: rtl/portcfg_pkg.sv
package portcfg_pkg;

  // unlock detector states
  typedef enum logic [1:0] {
    SQ_LOCKED = 2'd0,
    SQ_ONE    = 2'd1,
    SQ_TWO    = 2'd2,
    SQ_OPEN   = 2'd3
  } seq_state_t;

  localparam int AW    = 3;
  localparam int HW    = 16;
  localparam int RW    = 8;
  localparam int NSETS = 2;

  // offsets whose meaning the timing generator and host depend on
  localparam logic [AW-1:0] OFS_RDT   = 3'd0;
  localparam logic [AW-1:0] OFS_WRT   = 3'd1;
  localparam logic [AW-1:0] OFS_KEY   = 3'd2;
  localparam logic [AW-1:0] OFS_CTRL  = 3'd3;
  localparam logic [AW-1:0] OFS_VER   = 3'd5;
  localparam logic [AW-1:0] OFS_MISC  = 3'd6;

  localparam logic [RW-1:0] KEY_OPEN  = 8'h03;
  localparam logic [RW-1:0] KEY_CLOSE = 8'h83;

  localparam logic [RW-1:0] TIM_SLOW  = 8'hFF;
  localparam logic [RW-1:0] MISC_RST  = 8'h30;
  localparam logic [RW-1:0] CTRL_RST  = 8'h00;

  localparam int CTRL_BEN_BIT = 6;
  localparam int MISC_SEL_BIT = 0;

endpackage

// File: rtl/portcfg_seq.sv
module portcfg_seq
  import portcfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  input  logic          word,
  input  logic [RW-1:0] wdata,
  output logic          drv_rd,
  output logic          drv_wr,
  output logic          cfg_rd,
  output logic          cfg_wr,
  output logic          open
);

  seq_state_t state_q, state_d;
  logic acc, unl_rd, key_open, key_close, taken;

  always_comb begin
    acc       = rd | wr;
    unl_rd    = rd & ~wr & word & (addr == OFS_WRT);
    key_open  = wr & ~rd & ~word & (addr == OFS_KEY) & (wdata == KEY_OPEN);
    key_close = wr & ~rd & ~word & (addr == OFS_KEY) & (wdata == KEY_CLOSE);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_LOCKED: if (unl_rd) state_d = SQ_ONE;
      SQ_ONE:    if (unl_rd) state_d = SQ_TWO;   else if (acc) state_d = SQ_LOCKED;
      SQ_TWO:    if (key_open) state_d = SQ_OPEN; else if (acc) state_d = SQ_LOCKED;
      SQ_OPEN:   if (key_close) state_d = SQ_LOCKED;
      default:   state_d = SQ_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_LOCKED;
    else        state_q <= state_d;
  end

  always_comb begin
    open   = (state_q == SQ_OPEN);
    taken  = open ? acc : ((state_q == SQ_TWO) & key_open);
    drv_rd = rd & ~taken;
    drv_wr = wr & ~taken;
    cfg_rd = open & rd & ~wr;
    cfg_wr = open & wr & ~rd & (addr != OFS_KEY);
  end

  // R2
  open_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open) |-> $past(wr && !word && addr == OFS_KEY && wdata == KEY_OPEN));

  // R4
  close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(open) |-> $past(wr && addr == OFS_KEY && wdata == KEY_CLOSE));

  // R5
  cfg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_rd, cfg_wr, drv_rd | drv_wr}));

endmodule

// File: rtl/portcfg_regfile.sv
module portcfg_regfile
  import portcfg_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_rd,
  input  logic                      cfg_wr,
  input  logic [AW-1:0]             addr,
  input  logic [RW-1:0]             wdata,
  output logic [HW-1:0]             rdata,
  output logic [NSETS-1:0][RW-1:0]  rdt_q,
  output logic [NSETS-1:0][RW-1:0]  wrt_q,
  output logic [RW-1:0]             misc_q,
  output logic [RW-1:0]             ctrl_q
);

  localparam logic [RW-1:0] VERSION = '0;
  localparam int            SW      = $clog2(NSETS);

  logic [SW-1:0]    sel;
  logic             sel_ok;
  logic [NSETS-1:0] rdt_en, wrt_en;
  logic             misc_en, ctrl_en;
  logic [RW-1:0]    rbyte;

  always_comb begin
    sel     = SW'(misc_q[MISC_SEL_BIT]);
    sel_ok  = (sel == '0) | ctrl_q[CTRL_BEN_BIT];
    misc_en = cfg_wr & (addr == OFS_MISC);
    ctrl_en = cfg_wr & (addr == OFS_CTRL);
  end

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    always_comb begin
      rdt_en[s] = cfg_wr & sel_ok & (sel == SW'(s)) & (addr == OFS_RDT);
      wrt_en[s] = cfg_wr & sel_ok & (sel == SW'(s)) & (addr == OFS_WRT);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdt_q[s] <= TIM_SLOW;
        wrt_q[s] <= TIM_SLOW;
      end else begin
        if (rdt_en[s]) rdt_q[s] <= wdata;
        if (wrt_en[s]) wrt_q[s] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      misc_q <= MISC_RST;
      ctrl_q <= CTRL_RST;
    end else begin
      if (misc_en) misc_q <= wdata;
      if (ctrl_en) ctrl_q <= wdata;
    end
  end

  always_comb begin
    rbyte = '0;
    unique case (addr)
      OFS_RDT:  if (sel_ok) rbyte = rdt_q[sel];
      OFS_WRT:  if (sel_ok) rbyte = wrt_q[sel];
      OFS_CTRL: rbyte = ctrl_q;
      OFS_VER:  rbyte = VERSION;
      OFS_MISC: rbyte = misc_q;
      default:  rbyte = '0;
    endcase
    rdata = cfg_rd ? HW'(rbyte) : '0;
  end

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable({rdt_q, wrt_q, misc_q, ctrl_q}));

  // R8
  version_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && addr == OFS_VER) |-> (rdata == '0));

  // R7
  b_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[CTRL_BEN_BIT] && misc_q[MISC_SEL_BIT] == 1'b1) |=> $stable(rdt_q[NSETS-1]));

endmodule

// File: rtl/portcfg_window.sv
module portcfg_window
  import portcfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    host_addr,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic          host_word,
  input  logic [15:0]   host_wdata,
  output logic          drv_rd,
  output logic          drv_wr,
  output logic          cfg_rvalid,
  output logic [15:0]   cfg_rdata,
  output logic          win_open,
  output logic [7:0]    tim_a_rd,
  output logic [7:0]    tim_a_wr,
  output logic [7:0]    tim_b_rd,
  output logic [7:0]    tim_b_wr,
  output logic [7:0]    misc_q,
  output logic [7:0]    ctrl_q
);

  logic [1:0] rst_pipe;
  logic       rst_int_n;
  logic       cfg_rd, cfg_wr;
  logic [NSETS-1:0][RW-1:0] rdt_q, wrt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  portcfg_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .addr   (host_addr),
    .rd     (host_rd),
    .wr     (host_wr),
    .word   (host_word),
    .wdata  (host_wdata[RW-1:0]),
    .drv_rd (drv_rd),
    .drv_wr (drv_wr),
    .cfg_rd (cfg_rd),
    .cfg_wr (cfg_wr),
    .open   (win_open)
  );

  portcfg_regfile u_regs (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cfg_rd (cfg_rd),
    .cfg_wr (cfg_wr),
    .addr   (host_addr),
    .wdata  (host_wdata[RW-1:0]),
    .rdata  (cfg_rdata),
    .rdt_q  (rdt_q),
    .wrt_q  (wrt_q),
    .misc_q (misc_q),
    .ctrl_q (ctrl_q)
  );

  assign cfg_rvalid = cfg_rd;
  assign tim_a_rd   = rdt_q[0];
  assign tim_a_wr   = wrt_q[0];
  assign tim_b_rd   = rdt_q[1];
  assign tim_b_wr   = wrt_q[1];

  // R9
  closed_pass_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!win_open && host_rd && !host_wr) |-> drv_rd);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $rose(rst_int_n) |-> (!win_open && misc_q == MISC_RST && ctrl_q == CTRL_RST));

endmodule

// File: tb/portcfg_window_bench.sv
`timescale 1ns/1ps
module portcfg_window_bench;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0]  host_addr;
  logic        host_rd, host_wr, host_word;
  logic [15:0] host_wdata;
  logic        drv_rd, drv_wr, cfg_rvalid, win_open;
  logic [15:0] cfg_rdata;
  logic [7:0]  tim_a_rd, tim_a_wr, tim_b_rd, tim_b_wr, misc_q, ctrl_q;

  int checks = 0;
  int errors = 0;

  // bench model
  int       m_st;
  bit [7:0] m_rdt [2];
  bit [7:0] m_wrt [2];
  bit [7:0] m_misc, m_ctrl;

  always #2.5 clk = ~clk;

  portcfg_window u_portcfg_window (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_word(host_word), .host_wdata(host_wdata),
    .drv_rd(drv_rd), .drv_wr(drv_wr), .cfg_rvalid(cfg_rvalid),
    .cfg_rdata(cfg_rdata), .win_open(win_open), .tim_a_rd(tim_a_rd),
    .tim_a_wr(tim_a_wr), .tim_b_rd(tim_b_rd), .tim_b_wr(tim_b_wr),
    .misc_q(misc_q), .ctrl_q(ctrl_q)
  );

  function automatic bit sel_ok();
    return (m_misc[0] == 1'b0) || m_ctrl[6];
  endfunction

  function automatic bit [7:0] model_read(input bit [2:0] a);
    case (a)
      3'd0: return sel_ok() ? m_rdt[m_misc[0]] : 8'h00;
      3'd1: return sel_ok() ? m_wrt[m_misc[0]] : 8'h00;
      3'd3: return m_ctrl;
      3'd6: return m_misc;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    logic [56:0] act, exp;
    act = {tim_a_rd, tim_a_wr, tim_b_rd, tim_b_wr, misc_q, ctrl_q, 8'h00, win_open};
    exp = {m_rdt[0], m_wrt[0], m_rdt[1], m_wrt[1], m_misc, m_ctrl, 8'h00, (m_st == 3)};
    check(act === exp, tag, "regs", act, exp);
  endtask

  task automatic model_reset();
    m_st = 0; m_misc = 8'h30; m_ctrl = 8'h00;
    for (int s = 0; s < 2; s++) begin m_rdt[s] = 8'hFF; m_wrt[s] = 8'hFF; end
  endtask

  task automatic acc(input bit r, input bit w, input bit wd, input bit [2:0] a,
                     input bit [15:0] d, input string tag);
    bit unl, kop, kcl, taken, crd;
    bit [35:0] act, exp;
    @(negedge clk);
    host_rd = r; host_wr = w; host_word = wd; host_addr = a; host_wdata = d;
    #1;
    unl   = r && !w && wd && a == 3'd1;
    kop   = w && !r && !wd && a == 3'd2 && d[7:0] == 8'h03;
    kcl   = w && !r && !wd && a == 3'd2 && d[7:0] == 8'h83;
    taken = (m_st == 3) ? 1'b1 : (m_st == 2 && kop);
    crd   = (m_st == 3) && r && !w;
    exp = {r && !taken, w && !taken, crd, (crd ? {8'h00, model_read(a)} : 16'h0000), 16'h0};
    act = {drv_rd, drv_wr, cfg_rvalid, cfg_rdata, 16'h0};
    check(act === exp, tag, "port", act, exp);
    case (m_st)
      0: if (unl) m_st = 1;
      1: m_st = unl ? 2 : 0;
      2: m_st = kop ? 3 : 0;
      default: begin
        if (kcl) m_st = 0;
        else if (w && !r) begin
          case (a)
            3'd0: if (sel_ok()) m_rdt[m_misc[0]] = d[7:0];
            3'd1: if (sel_ok()) m_wrt[m_misc[0]] = d[7:0];
            3'd3: m_ctrl = d[7:0];
            3'd6: m_misc = d[7:0];
            default: ;
          endcase
        end
      end
    endcase
    @(posedge clk); #1;
    host_rd = 0; host_wr = 0;
    check_regs(tag);
  endtask

  task automatic unlock(input string tag);
    acc(1, 0, 1, 3'd1, 16'h0, tag);
    acc(1, 0, 1, 3'd1, 16'h0, tag);
    acc(0, 1, 0, 3'd2, 16'h0003, tag);
  endtask

  function automatic bit [15:0] pick_data();
    case ($urandom_range(0, 7))
      0: return 16'h0003;
      1: return 16'h0083;
      2: return 16'h00C0;
      3: return 16'h0001;
      4: return 16'h0000;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4177));
    host_rd = 0; host_wr = 0; host_word = 0; host_addr = 0; host_wdata = 0;
    rst_n = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk); #1;
    check_regs("R1");

    // R9 closed pass-through
    acc(0, 1, 1, 3'd0, 16'h1234, "R9");
    acc(1, 0, 0, 3'd7, 16'h0, "R9");
    // R3 broken orders
    acc(1, 0, 1, 3'd1, 16'h0, "R3");
    acc(1, 0, 0, 3'd1, 16'h0, "R3");           // byte read breaks
    acc(1, 0, 1, 3'd1, 16'h0, "R3");
    acc(1, 0, 1, 3'd1, 16'h0, "R3");
    acc(0, 1, 0, 3'd2, 16'h0083, "R3");        // wrong key, forwarded
    acc(0, 1, 0, 3'd2, 16'h0003, "R3");        // without reads: forwarded
    // R2 open
    unlock("R2");
    // R6 set A
    acc(0, 1, 0, 3'd0, 16'h0021, "R6");
    acc(0, 1, 0, 3'd1, 16'h0032, "R6");
    acc(1, 0, 0, 3'd0, 16'h0, "R6");
    // R7 set B without enable: dropped
    acc(0, 1, 0, 3'd6, 16'h0001, "R10");
    acc(0, 1, 0, 3'd0, 16'h0055, "R7");
    acc(1, 0, 0, 3'd0, 16'h0, "R7");
    acc(0, 1, 0, 3'd3, 16'h00C0, "R10");
    acc(0, 1, 0, 3'd0, 16'h0066, "R7");
    acc(0, 1, 0, 3'd1, 16'h0077, "R7");
    acc(1, 0, 1, 3'd1, 16'h0, "R7");
    // R8 version / R5 unmapped
    acc(0, 1, 0, 3'd5, 16'h00AA, "R8");
    acc(1, 0, 0, 3'd5, 16'h0, "R8");
    acc(1, 0, 0, 3'd4, 16'h0, "R5");
    acc(0, 1, 0, 3'd2, 16'h0003, "R5");
    acc(1, 0, 0, 3'd7, 16'h0, "R5");
    acc(1, 0, 0, 3'd6, 16'h0, "R10");
    // R4 close
    acc(0, 1, 0, 3'd2, 16'h0083, "R4");
    acc(0, 1, 0, 3'd0, 16'h00EE, "R9");
    acc(1, 0, 1, 3'd3, 16'h0, "R9");

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 9) < 2) unlock("R2");
      else begin
        bit r;
        r = $urandom_range(0, 1);
        acc(r, !r, $urandom_range(0, 1), 3'($urandom_range(0, 7)), pick_data(),
            (m_st == 3) ? "R5" : "R3");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule